// File: doc/BRIEF.md
# Four-Beat Burst Word-Address Generator

This block turns one externally supplied word address into the sequence of four word addresses that a burst visits. On a load cycle it captures the external address as the start of a new burst. On each advance cycle it moves to the next word of the burst. Only the two low address bits take part in the burst; the bits above them keep the value that was captured.

The visiting order is chosen by a static mode input. In wrap order the low bits count upward modulo four from the start value. In exchange order they are the start bits XORed with a beat index that runs 0, 1, 2, 3. Load and advance share one strobe. An active freeze input makes the block ignore that strobe and keep its state. The memory array and the data path sit outside the block.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the captured address and the beat index, so `addr_out` reads zero in the cycle after a reset edge. Reset takes priority over every other input.
- R2: On a rising edge with `freeze`=0 and `advance`=0, `addr_in` is captured and the beat index returns to zero. After that edge `addr_out` equals `addr_in`.
- R3: With `order_xor`=0, after k advance edges since the last load, the low two bits of `addr_out` equal (start + k) mod 4.
- R4: With `order_xor`=1, after k advance edges since the last load, the low two bits of `addr_out` equal start XOR (k mod 4).
- R5: Bits `ADDR_W-1` down to 2 of `addr_out` do not change on advance edges.
- R6: The fourth advance after a load brings `addr_out` back to the loaded address. The burst never carries into the next group of four words.
- R7: While `freeze`=1, rising edges change neither the captured address nor the beat index, whatever `advance` and `addr_in` are.
- R8: A load in the middle of a burst drops the rest of that burst and starts a new one at beat zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | 1 holds all state and ignores the strobe |
| advance | input | 1 | 0 loads `addr_in`, 1 steps to the next beat |
| order_xor | input | 1 | Static burst order: 0 wrap order, 1 exchange order |
| addr_in | input | ADDR_W | External start word address |
| addr_out | output | ADDR_W | Current word address of the burst |

## Verification
The bench runs every start value of the low two bits in both orders, each with several upper-bit patterns. It walks each burst through all four beats and one beat more. This separates an add-based step from an XOR-based step and shows whether the fifth address wraps back or carries into the upper bits. Freeze cycles are given both a load and an advance, with a different `addr_in` present, to show that neither one leaks through. A reload in the middle of a burst and a reset in the middle of a burst show that the beat index restarts from zero.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_WRAP = 1'b0,
        ORDER_XCHG = 1'b1
    } order_e;

    typedef struct packed {
        logic load_en;
        logic step_en;
    } ctl_t;

    function automatic beat_t map_beat(order_e ord, beat_t start, beat_t idx);
        if (ord == ORDER_XCHG) begin
            return start ^ idx;
        end
        return beat_t'(start + idx);
    endfunction

endpackage

// File: rtl/bag_ctl_decode.sv
module bag_ctl_decode
    import burst_addr_pkg::*;
(
    input  logic freeze,
    input  logic advance,
    output ctl_t ctl
);
    always_comb begin
        ctl.load_en = !freeze && !advance;
        ctl.step_en = !freeze && advance;
    end
endmodule

// File: rtl/bag_start_reg.sv
module bag_start_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] start_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (ctl.load_en) begin
            start_q <= addr_in;
        end
    end

    // R5, R7: the captured start moves only on a load
    assert_start_held_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl.load_en |=> $stable(start_q));
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    output beat_t beat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (ctl.load_en) begin
            beat_q <= '0;
        end else if (ctl.step_en) begin
            beat_q <= beat_t'(beat_q + 1'b1);
        end
    end

    assert_beat_step_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.step_en |=> beat_q == beat_t'($past(beat_q) + 1'b1));

    assert_beat_restart_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.load_en |=> beat_q == '0);
endmodule

// File: rtl/bag_low_map.sv
module bag_low_map
    import burst_addr_pkg::*;
(
    input  order_e ord,
    input  beat_t  start_lo,
    input  beat_t  beat,
    output beat_t  low_out
);
    always_comb begin
        low_out = map_beat(ord, start_lo, beat);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic              advance,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    ctl_t              ctl;
    logic [ADDR_W-1:0] start_q;
    beat_t             beat_q;
    beat_t             low_w;
    order_e            ord;

    assign ord = order_e'(order_xor);

    bag_ctl_decode u_dec (
        .freeze  (freeze),
        .advance (advance),
        .ctl     (ctl)
    );

    bag_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .addr_in (addr_in),
        .start_q (start_q)
    );

    bag_beat_ctr u_beat (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .beat_q (beat_q)
    );

    bag_low_map u_map (
        .ord      (ord),
        .start_lo (start_q[BEAT_W-1:0]),
        .beat     (beat_q),
        .low_out  (low_w)
    );

    assign addr_out = {start_q[ADDR_W-1:BEAT_W], low_w};

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> addr_out == '0);

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
        !freeze && !advance |=> addr_out == $past(addr_in));

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        !freeze && advance |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    assert_hold_out_R7: assert property (@(posedge clk) disable iff (rst)
        freeze && $stable(order_xor) |=> $stable(addr_out));

    initial begin
        assert (HI_W >= 1) else $error("ADDR_W must exceed the beat width");
    end
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 20;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          freeze = 1'b0;
    logic          advance = 1'b0;
    logic          order_xor = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .freeze(freeze), .advance(advance),
        .order_xor(order_xor), .addr_in(addr_in), .addr_out(addr_out)
    );

    task automatic chk(input string req, input logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, addr_out, exp);
        end
    endtask

    // apply inputs after a falling edge, let one rising edge pass, settle at next fall
    task automatic cyc(input logic r, input logic f, input logic adv, input logic [AW-1:0] a);
        rst = r; freeze = f; advance = adv; addr_in = a;
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s, input int k, input bit x);
        logic [1:0] lo;
        if (x) lo = s[1:0] ^ 2'(k % 4);
        else   lo = 2'((int'(s[1:0]) + k) % 4);
        return {s[AW-1:2], lo};
    endfunction

    initial begin
        logic [AW-1:0] uppers [3];
        uppers[0] = '0;
        uppers[1] = {2'b10, {(AW-4){1'b1}}, 2'b00};
        uppers[2] = 20'h5A5A4;
        @(negedge clk);
        cyc(1, 0, 0, 20'hABCDE);
        chk("R1 reset", '0);

        for (int m = 0; m < 2; m++) begin
            order_xor = m[0];
            for (int u = 0; u < 3; u++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [AW-1:0] st;
                    st = {uppers[u][AW-1:2], 2'(s)};
                    cyc(0, 0, 0, st);
                    chk("R2 load", st);
                    for (int k = 1; k <= 5; k++) begin
                        cyc(0, 0, 1, ~st);
                        if (k == 4) chk("R6 wrap", st);
                        else if (m == 0) chk("R3 wrap-order beat", expect_addr(st, k, 0));
                        else chk("R4 xchg-order beat", expect_addr(st, k, 1));
                        checks++;
                        if (addr_out[AW-1:2] !== st[AW-1:2]) begin
                            failures++;
                            $display("FAIL R5 upper got=%h exp=%h", addr_out[AW-1:2], st[AW-1:2]);
                        end
                    end
                end
            end
        end

        // R7: freeze ignores both load and advance
        for (int m = 0; m < 2; m++) begin
            order_xor = m[0];
            cyc(0, 0, 0, 20'h12345);
            cyc(0, 0, 1, '0);
            cyc(0, 1, 0, 20'hFFFFF);
            chk("R7 freeze with load", expect_addr(20'h12345, 1, m[0]));
            cyc(0, 1, 1, 20'h0);
            cyc(0, 1, 1, 20'h0);
            chk("R7 freeze with advance", expect_addr(20'h12345, 1, m[0]));
            cyc(0, 0, 1, '0);
            chk("R7 resume after freeze", expect_addr(20'h12345, 2, m[0]));
        end

        // R8: reload mid burst restarts at beat zero
        for (int m = 0; m < 2; m++) begin
            order_xor = m[0];
            cyc(0, 0, 0, 20'h00031);
            cyc(0, 0, 1, '0);
            cyc(0, 0, 1, '0);
            cyc(0, 0, 0, 20'h77772);
            chk("R8 reload", 20'h77772);
            cyc(0, 0, 1, '0);
            chk("R8 beat after reload", expect_addr(20'h77772, 1, m[0]));
        end

        // R1: reset mid burst beats a simultaneous load
        cyc(0, 0, 1, '0);
        cyc(1, 0, 0, 20'h44444);
        chk("R1 reset mid burst", '0);
        cyc(0, 0, 1, '0);
        chk("R1 advance from reset", expect_addr('0, 1, order_xor));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule